// File: doc/BRIEF.md
# Group-Bypass Carry Adder

A purely combinational binary adder. Operands are split into equal slices, and a carry ripples bit by bit through each slice. Every slice also forms one signal that says whether all of its bits would pass a carry through unchanged. When that signal is set, the slice's incoming carry skips the internal chain and goes straight to the slice's outgoing carry through a 2:1 selector. The longest path is a carry made in the lowest bit that ripples to the top of the first slice. It then jumps over every middle slice and ripples through the last one.

The width and the slice size are parameters. The slice size must divide the width exactly, and any other setting stops elaboration. The default is 16 bits in four slices of 4 bits. The block has no state, so a result is valid once its inputs settle.

Top module: `cskip_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i`, for any operands and carry-in.
- R2: `cout_o` equals bit WIDTH of `a_i + b_i + cin_i`, which is the outgoing carry of the most significant slice.
- R3: When every bit of a slice has `a_i ^ b_i` = 1, that slice's outgoing carry equals its incoming carry. At the ports, the next slice adds as if it received the carry that entered the bypassed slice.
- R4: When some bit of a slice has `a_i ^ b_i` = 0, the slice's outgoing carry is decided inside the slice and does not depend on its incoming carry. At the ports, toggling `cin_i` leaves `cout_o` unchanged. It also leaves unchanged every `sum_o` bit above the lowest such slice.
- R5: With `b_i = ~a_i` (all bits propagate), `cin_i` = 0 gives `sum_o` all ones and `cout_o` 0. `cin_i` = 1 gives `sum_o` all zeros and `cout_o` 1.
- R6: A carry made in bit 0 while bits 1 to WIDTH-1 all propagate gives `sum_o` = 0 and `cout_o` = 1. An example is `a_i` = 1, `b_i` = all ones, `cin_i` = 0.
- R7: The result is correct for any WIDTH that is a whole multiple of the slice size GRP, including a small 6-bit, 2-bit-slice build.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The bypass path and the internal ripple chain can both produce a slice's outgoing carry for the same operands. When every bit propagates, both paths give the same value, so a wrong selector is hidden unless the ripple chain itself is wrong. Full-propagate operands therefore go in with both carry-in values, and a single slice is made to propagate among random neighbours. Each result is judged against a plain arithmetic sum. Pairs of vectors that differ only in carry-in show whether a slice that does not propagate wrongly passes the carry through.

// File: rtl/cskip_adder.sv
module cskip_adder #(
  parameter int WIDTH = 16,
  parameter int GRP   = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NGRP = WIDTH / GRP;

  if (GRP < 1 || (WIDTH % GRP) != 0) begin : g_bad_cfg
    $error("cskip_adder: WIDTH must be a whole multiple of GRP");
  end

  logic [WIDTH-1:0] p, g, cbit;
  logic [NGRP:0]    gc;
  logic [NGRP-1:0]  bp, rip;

  assign p     = a_i ^ b_i;
  assign g     = a_i & b_i;
  assign gc[0] = cin_i;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    localparam int LO = k * GRP;
    logic [GRP:0] ch;
    assign ch[0] = gc[k];
    for (genvar j = 0; j < GRP; j++) begin : g_bit
      assign ch[j+1]    = g[LO+j] | (p[LO+j] & ch[j]);
      assign cbit[LO+j] = ch[j];
    end
    assign rip[k]  = ch[GRP];
    assign bp[k]   = &p[LO +: GRP];
    assign gc[k+1] = bp[k] ? gc[k] : rip[k];
  end

  assign sum_o  = p ^ cbit;
  assign cout_o = gc[NGRP];
endmodule

// File: rtl/cskip_adder_chk.sv
module cskip_adder_chk #(
  parameter int WIDTH = 16,
  parameter int GRP   = 4
) (
  input logic [WIDTH-1:0]      a_i,
  input logic [WIDTH-1:0]      b_i,
  input logic                  cin_i,
  input logic [WIDTH-1:0]      sum_o,
  input logic                  cout_o,
  input logic [WIDTH/GRP:0]    gc,
  input logic [WIDTH/GRP-1:0]  bp
);
  localparam int NGRP = WIDTH / GRP;

  function automatic logic grp_gen(input logic [GRP-1:0] x, input logic [GRP-1:0] y);
    logic [GRP:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[GRP];
  endfunction

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i);

  always_comb begin
    // R1
    sum_match_chk: assert (sum_o == ref_sum[WIDTH-1:0]);
    // R2
    cout_match_chk: assert (cout_o == ref_sum[WIDTH]);
    // R5
    full_prop_chk: assert (((a_i ^ b_i) != {WIDTH{1'b1}}) ||
                           (sum_o == {WIDTH{~cin_i}} && cout_o == cin_i));
    for (int k = 0; k < NGRP; k++) begin
      // R3
      skip_pass_chk: assert (!bp[k] || gc[k+1] == gc[k]);
      // R4
      local_carry_chk: assert (bp[k] ||
                               gc[k+1] == grp_gen(a_i[k*GRP +: GRP], b_i[k*GRP +: GRP]));
    end
  end
endmodule

bind cskip_adder cskip_adder_chk #(.WIDTH(WIDTH), .GRP(GRP)) chk_i (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o),
  .gc(gc), .bp(bp)
);

// File: tb/cskip_adder_tb_top.sv
module cskip_adder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] a, b, s;
  logic        ci, co;
  logic [5:0]  sa, sb, ss;
  logic        sci, sco;

  cskip_adder #(.WIDTH(16), .GRP(4)) dut_i (
    .a_i(a), .b_i(b), .cin_i(ci), .sum_o(s), .cout_o(co));
  cskip_adder #(.WIDTH(6), .GRP(2)) small_i (
    .a_i(sa), .b_i(sb), .cin_i(sci), .sum_o(ss), .cout_o(sco));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c);
    @(posedge clk);
    #2;
    a = x; b = y; ci = c;
    #1;
  endtask

  task automatic arith(input string req);
    logic [16:0] e;
    e = {1'b0, a} + {1'b0, b} + 17'(ci);
    chk({req, " R1 sum"}, 32'(s), 32'(e[15:0]));
    chk({req, " R2 cout"}, 32'(co), 32'(e[16]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    a = '0; b = '0; ci = 1'b0; sa = '0; sb = '0; sci = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #3;
    chk("R1 idle sum", 32'(s), 0);
    chk("R2 idle cout", 32'(co), 0);

    // R5 full propagate, both carry-in values
    for (int i = 0; i < 64; i++) begin
      logic [15:0] x;
      x = 16'($urandom);
      apply(x, ~x, 1'b0);
      chk("R5 cin0 sum", 32'(s), 32'hFFFF);
      chk("R5 cin0 cout", 32'(co), 0);
      apply(x, ~x, 1'b1);
      chk("R5 cin1 sum", 32'(s), 0);
      chk("R5 cin1 cout", 32'(co), 1);
    end

    // R6 worst-case path
    apply(16'h0001, 16'hFFFF, 1'b0);
    chk("R6 sum", 32'(s), 0);
    chk("R6 cout", 32'(co), 1);
    apply(16'hFFFF, 16'h0001, 1'b0);
    chk("R6 swapped sum", 32'(s), 0);
    chk("R6 swapped cout", 32'(co), 1);

    // R3 one slice fully propagating among random neighbours
    for (int i = 0; i < 400; i++) begin
      logic [15:0] x, y;
      int k;
      k = i % 4;
      x = 16'($urandom);
      y = 16'($urandom);
      y[k*4 +: 4] = ~x[k*4 +: 4];
      apply(x, y, 1'($urandom));
      arith("R3");
    end

    // R4 carry-in does not cross a slice that does not propagate
    for (int i = 0; i < 400; i++) begin
      logic [15:0] x, y, p, s0;
      logic        c0;
      int lo;
      x = 16'($urandom);
      y = 16'($urandom);
      p = x ^ y;
      lo = -1;
      for (int k = 3; k >= 0; k--) if (p[k*4 +: 4] != 4'hF) lo = k;
      if (lo < 0) continue;
      apply(x, y, 1'b0);
      s0 = s; c0 = co;
      apply(x, y, 1'b1);
      chk("R4 cout", 32'(co), 32'(c0));
      chk("R4 upper sum", 32'(s >> ((lo + 1) * 4)), 32'(s0 >> ((lo + 1) * 4)));
    end

    // R1 R2 random operands
    for (int i = 0; i < 3000; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      arith("random");
    end

    // R7 exhaustive over small build
    for (int v = 0; v < 8192; v++) begin
      logic [6:0] e;
      @(posedge clk);
      #2;
      sa = v[5:0]; sb = v[11:6]; sci = v[12];
      #1;
      e = {1'b0, sa} + {1'b0, sb} + 7'(sci);
      chk("R7 small sum", 32'(ss), 32'(e[5:0]));
      chk("R7 small cout", 32'(sco), 32'(e[6]));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule